// File: doc/BRIEF.md
# Receive Frame Screening Classifier

This block watches an incoming Ethernet frame, one byte per accepted beat, and chooses the receive priority queue that the frame belongs to. Software programs two banks of screeners through a simple word-write port. A first-tier screener compares the UDP destination port and the IP DS/TC byte. A second-tier screener compares the EtherType against one of a set of EtherType registers and can apply up to three masked 16-bit compares. Each compare reads a half-word at an offset measured from a chosen protocol layer.

The frame is never stored. While the bytes stream past, a fixed set of capture units picks out only the bytes that some screener tests. When the last byte has been accepted, the block evaluates every screener. It then issues a one-cycle strobe that carries the queue number. The configuration must stay stable while a frame is in flight.

Top module: `frame_screen_classifier`

## Requirements
- R1: A beat is accepted when `rx_valid` is high and either `rx_first` is high or a frame is open. A beat with `rx_first` is frame byte 0. Each later accepted beat is the next position. An accepted beat with `rx_last` closes the frame. Beats that arrive while no frame is open are ignored.
- R2: `cls_valid` is high for exactly one cycle. It comes two rising edges after the edge that accepts the last byte, and at no other time.
- R3: First-tier word fields: bit 29 enables the UDP port test, bits 27:12 hold the port, and bits 3:0 hold the target queue. The port is frame bytes 36 (high) and 37 (low).
- R4: First-tier word fields: bit 28 enables the DS/TC test and bits 11:4 hold the value compared with frame byte 15.
- R5: A screener hits only when at least one of its enabled tests matches and none of its enabled tests mismatches. A screener with no enabled test never hits.
- R6: First-tier screeners are tried in index order, then second-tier screeners in index order. The first hit gives the queue. When no screener hits, the queue is 0.
- R7: Second-tier word fields: bit 12 enables the EtherType test, bits 11:9 select an EtherType register, and bits 3:0 hold the target queue. The test compares frame bytes 12 (high) and 13 (low) with bits 15:0 of that register.
- R8: Second-tier compares A, B and C use enable bits 18, 24 and 30 and index fields 17:13, 23:19 and 29:25. Compare entry k occupies words 2k and 2k+1. Word 0 holds the mask in bits 15:0 and the value in bits 31:16. A compare matches when (half-word AND mask) equals (value AND mask).
- R9: Entry word 1 holds the offset in bits 6:0 and the base in bits 8:7. The base adds 0, 14, 34 or 42 to the offset. The half-word is byte[position] high and byte[position+1] low.
- R10: A test whose bytes lie beyond the end of the frame is a mismatch. A compare whose index is not below the number of compare entries is a mismatch.
- R11: Write address bits 6:5 select the bank: 0 first tier, 1 second tier, 2 EtherType, 3 compare words. Bits 4:0 are the index. A write to an index beyond the bank size changes nothing.
- R12: Reset clears every configuration word and holds `cls_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_first | input | 1 | Beat is frame byte 0 |
| rx_last | input | 1 | Beat is the final frame byte |
| rx_byte | input | 8 | Frame byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Bank select (6:5) and index (4:0) |
| cfg_wdata | input | 32 | Configuration write data |
| cls_valid | output | 1 | Queue decision strobe |
| cls_queue | output | 4 | Selected receive queue |

## Verification
On every cycle, the assertions check the timing of the decision strobe: it is a single-cycle pulse, it follows every accepted last byte after exactly two edges, and it never appears without one. They also check that a stray last byte outside a frame produces no strobe, and that an all-zero configuration always yields queue 0. The bench scenarios are the only place that shows which queue is chosen. They cover the field positions, the two-tier priority, the match and mismatch rule, the offset bases, short frames, out-of-range indices and ignored writes, with expected queues derived from known frame contents.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int ADDR_W = 7;
    localparam int IDX_W  = 5;
    localparam int POS_W  = 8;

    typedef enum logic [1:0] {
        BANK_TIER1 = 2'd0,
        BANK_TIER2 = 2'd1,
        BANK_ETYPE = 2'd2,
        BANK_CMP   = 2'd3
    } bank_e;

    // fixed frame positions
    localparam logic [POS_W-1:0] POS_ETYPE = 8'd12;
    localparam logic [POS_W-1:0] POS_DSTC  = 8'd15;
    localparam logic [POS_W-1:0] POS_UDP   = 8'd36;

    // tier-1 fields
    localparam int T1_UDP_EN = 29;
    localparam int T1_DS_EN  = 28;
    // tier-2 fields
    localparam int T2_ET_EN  = 12;
    localparam int T2_CMP_EN = 18;
    localparam int T2_CMP_IX = 13;
    localparam int T2_STRIDE = 6;

    function automatic logic [POS_W-1:0] layer_base(input logic [1:0] sel);
        case (sel)
            2'd0:    layer_base = 8'd0;
            2'd1:    layer_base = 8'd14;
            2'd2:    layer_base = 8'd34;
            default: layer_base = 8'd42;
        endcase
    endfunction
endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
    import fsc_pkg::*;
#(
    parameter int NT1  = 4,
    parameter int NT2  = 4,
    parameter int NET  = 8,
    parameter int NCMP = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [31:0]                 wdata_i,
    output logic [NT1-1:0][31:0]        t1_o,
    output logic [NT2-1:0][31:0]        t2_o,
    output logic [NET-1:0][15:0]        et_o,
    output logic [2*NCMP-1:0][31:0]     cmp_o
);
    localparam int NCW = 2 * NCMP;

    typedef struct packed {
        logic [NT1-1:0][31:0] t1;
        logic [NT2-1:0][31:0] t2;
        logic [NET-1:0][15:0] et;
        logic [NCW-1:0][31:0] cmp;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [1:0]       bank;
    logic [IDX_W-1:0] idx;

    assign bank = addr_i[ADDR_W-1 -: 2];
    assign idx  = addr_i[IDX_W-1:0];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (bank)
                BANK_TIER1:
                    for (int k = 0; k < NT1; k++)
                        if (idx == IDX_W'(k)) regs_d.t1[k] = wdata_i;
                BANK_TIER2:
                    for (int k = 0; k < NT2; k++)
                        if (idx == IDX_W'(k)) regs_d.t2[k] = wdata_i;
                BANK_ETYPE:
                    for (int k = 0; k < NET; k++)
                        if (idx == IDX_W'(k)) regs_d.et[k] = wdata_i[15:0];
                default:
                    for (int k = 0; k < NCW; k++)
                        if (idx == IDX_W'(k)) regs_d.cmp[k] = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign t1_o  = regs_q.t1;
    assign t2_o  = regs_q.t2;
    assign et_o  = regs_q.et;
    assign cmp_o = regs_q.cmp;
endmodule

// File: rtl/fsc_hw_capture.sv
module fsc_hw_capture
    import fsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             sof_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [7:0]       data_i,
    input  logic [POS_W-1:0] tgt_i,
    output logic [15:0]      hw_o,
    output logic             hi_ok_o,
    output logic             ok_o
);
    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
        logic       hi_v;
        logic       lo_v;
    } cap_t;

    cap_t cap_d, cap_q;
    logic hit_hi, hit_lo;

    assign hit_hi = (pos_i == tgt_i);
    assign hit_lo = ({1'b0, pos_i} == ({1'b0, tgt_i} + 9'd1));

    always_comb begin
        cap_d = cap_q;
        if (acc_i) begin
            if (sof_i) begin
                cap_d.hi_v = 1'b0;
                cap_d.lo_v = 1'b0;
            end
            if (hit_hi) begin
                cap_d.hi   = data_i;
                cap_d.hi_v = 1'b1;
            end
            if (hit_lo) begin
                cap_d.lo   = data_i;
                cap_d.lo_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign hw_o    = {cap_q.hi, cap_q.lo};
    assign hi_ok_o = cap_q.hi_v;
    assign ok_o    = cap_q.hi_v & cap_q.lo_v;
endmodule

// File: rtl/fsc_match.sv
module fsc_match
    import fsc_pkg::*;
#(
    parameter int NT1 = 4,
    parameter int NT2 = 4,
    parameter int NET = 8
) (
    input  logic [NT1-1:0][31:0]   t1_i,
    input  logic [NT2-1:0][31:0]   t2_i,
    input  logic [NET-1:0][15:0]   et_i,
    input  logic [15:0]            udp_hw_i,
    input  logic                   udp_ok_i,
    input  logic [7:0]             ds_i,
    input  logic                   ds_ok_i,
    input  logic [15:0]            et_hw_i,
    input  logic                   et_ok_i,
    input  logic [NT2*3-1:0][15:0] slot_hw_i,
    input  logic [NT2*3-1:0]       slot_ok_i,
    input  logic [NT2*3-1:0]       slot_sel_i,
    input  logic [NT2*3-1:0][31:0] slot_w0_i,
    output logic [3:0]             queue_o
);
    always_comb begin
        logic        m, mm, et_found;
        logic [31:0] r;
        logic [15:0] et_val, msk;
        int          sl;
        queue_o = '0;
        // lowest index of the lowest tier is applied last and therefore wins
        for (int s = NT2 - 1; s >= 0; s--) begin
            r  = t2_i[s];
            m  = 1'b0;
            mm = 1'b0;
            et_found = 1'b0;
            et_val   = '0;
            for (int e = 0; e < NET; e++) begin
                if (r[11:9] == 3'(e)) begin
                    et_found = 1'b1;
                    et_val   = et_i[e];
                end
            end
            if (r[T2_ET_EN]) begin
                if (et_found && et_ok_i && (et_hw_i == et_val)) m = 1'b1;
                else                                             mm = 1'b1;
            end
            for (int j = 0; j < 3; j++) begin
                sl  = s * 3 + j;
                msk = slot_w0_i[sl][15:0];
                if (r[T2_CMP_EN + T2_STRIDE * j]) begin
                    if (slot_sel_i[sl] && slot_ok_i[sl] &&
                        ((slot_hw_i[sl] & msk) == (slot_w0_i[sl][31:16] & msk)))
                        m = 1'b1;
                    else
                        mm = 1'b1;
                end
            end
            if (m && !mm) queue_o = r[3:0];
        end
        for (int s = NT1 - 1; s >= 0; s--) begin
            r  = t1_i[s];
            m  = 1'b0;
            mm = 1'b0;
            if (r[T1_UDP_EN]) begin
                if (udp_ok_i && (udp_hw_i == r[27:12])) m = 1'b1;
                else                                     mm = 1'b1;
            end
            if (r[T1_DS_EN]) begin
                if (ds_ok_i && (ds_i == r[11:4])) m = 1'b1;
                else                              mm = 1'b1;
            end
            if (m && !mm) queue_o = r[3:0];
        end
    end
endmodule

// File: rtl/frame_screen_classifier.sv
module frame_screen_classifier
    import fsc_pkg::*;
#(
    parameter int NT1  = 4,
    parameter int NT2  = 4,
    parameter int NET  = 8,
    parameter int NCMP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              rx_last,
    input  logic [7:0]        rx_byte,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              cls_valid,
    output logic [3:0]        cls_queue
);
    localparam int NSLOT = NT2 * 3;
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             busy;
        logic             done;
        logic             qv;
        logic [3:0]       qn;
    } state_t;

    state_t st_d, st_q;

    logic [NT1-1:0][31:0]    t1_w;
    logic [NT2-1:0][31:0]    t2_w;
    logic [NET-1:0][15:0]    et_w;
    logic [2*NCMP-1:0][31:0] cmp_w;

    logic             acc;
    logic [POS_W-1:0] pos;
    logic [15:0]      udp_hw, et_hw, ds_hw;
    logic             udp_ok, et_ok, ds_ok, ds_unused, udp_hi, et_hi;
    logic [NSLOT-1:0][15:0] slot_hw;
    logic [NSLOT-1:0][31:0] slot_w0;
    logic [NSLOT-1:0]       slot_ok, slot_sel, slot_hi;
    logic [3:0]             match_q;

    assign acc = rx_valid && (rx_first || st_q.busy);
    assign pos = rx_first ? '0 : st_q.cnt;

    fsc_cfg_regs #(.NT1(NT1), .NT2(NT2), .NET(NET), .NCMP(NCMP)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
        .wdata_i(cfg_wdata), .t1_o(t1_w), .t2_o(t2_w), .et_o(et_w),
        .cmp_o(cmp_w)
    );

    fsc_hw_capture u_cap_udp (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .sof_i(rx_first), .pos_i(pos),
        .data_i(rx_byte), .tgt_i(POS_UDP), .hw_o(udp_hw), .hi_ok_o(udp_hi),
        .ok_o(udp_ok)
    );
    fsc_hw_capture u_cap_et (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .sof_i(rx_first), .pos_i(pos),
        .data_i(rx_byte), .tgt_i(POS_ETYPE), .hw_o(et_hw), .hi_ok_o(et_hi),
        .ok_o(et_ok)
    );
    fsc_hw_capture u_cap_ds (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .sof_i(rx_first), .pos_i(pos),
        .data_i(rx_byte), .tgt_i(POS_DSTC), .hw_o(ds_hw), .hi_ok_o(ds_ok),
        .ok_o(ds_unused)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam int S = g / 3;
        localparam int J = g % 3;
        logic [IDX_W-1:0] cidx;
        logic [31:0]      w1;
        logic [POS_W-1:0] tgt;

        assign cidx = t2_w[S][T2_CMP_IX + T2_STRIDE * J +: IDX_W];

        always_comb begin
            slot_sel[g] = 1'b0;
            slot_w0[g]  = '0;
            w1          = '0;
            for (int k = 0; k < NCMP; k++) begin
                if (cidx == IDX_W'(k)) begin
                    slot_sel[g] = 1'b1;
                    slot_w0[g]  = cmp_w[2*k];
                    w1          = cmp_w[2*k+1];
                end
            end
            tgt = {1'b0, w1[6:0]} + layer_base(w1[8:7]);
        end

        fsc_hw_capture u_cap (
            .clk(clk), .rst_n(rst_n), .acc_i(acc), .sof_i(rx_first),
            .pos_i(pos), .data_i(rx_byte), .tgt_i(tgt), .hw_o(slot_hw[g]),
            .hi_ok_o(slot_hi[g]), .ok_o(slot_ok[g])
        );
    end

    fsc_match #(.NT1(NT1), .NT2(NT2), .NET(NET)) u_match (
        .t1_i(t1_w), .t2_i(t2_w), .et_i(et_w),
        .udp_hw_i(udp_hw), .udp_ok_i(udp_ok),
        .ds_i(ds_hw[15:8]), .ds_ok_i(ds_ok),
        .et_hw_i(et_hw), .et_ok_i(et_ok),
        .slot_hw_i(slot_hw), .slot_ok_i(slot_ok), .slot_sel_i(slot_sel),
        .slot_w0_i(slot_w0), .queue_o(match_q)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (acc) begin
            st_d.cnt  = (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
            st_d.busy = !rx_last;
            st_d.done = rx_last;
        end
        st_d.qv = st_q.done;
        st_d.qn = st_q.done ? match_q : 4'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cls_valid = st_q.qv;
    assign cls_queue = st_q.qn;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int NT1 = 4,
    parameter int NT2 = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 rx_first,
    input logic                 rx_last,
    input logic                 acc,
    input logic                 busy,
    input logic [NT1-1:0][31:0] t1,
    input logic [NT2-1:0][31:0] t2,
    input logic                 cls_valid,
    input logic [3:0]           cls_queue
);
    logic cfg_zero;
    assign cfg_zero = (t1 == '0) && (t2 == '0);

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |=> !cls_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rx_last) |-> ##2 cls_valid);

    assert_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> $past(acc && rx_last, 2));

    assert_stray_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rx_valid && !rx_first && rx_last) |-> ##2 !cls_valid);

    assert_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && $past(cfg_zero)) |-> (cls_queue == 4'd0));
endmodule

bind frame_screen_classifier fsc_checker #(.NT1(NT1), .NT2(NT2)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_last(rx_last), .acc(acc), .busy(st_q.busy), .t1(t1_w), .t2(t2_w),
    .cls_valid(cls_valid), .cls_queue(cls_queue)
);

// File: tb/frame_screen_classifier_tb_top.sv
module frame_screen_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cls_valid;
    logic [3:0]  cls_queue;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  ended = 1'b0;
    logic [7:0] fr [0:199];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_screen_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_last(rx_last), .rx_byte(rx_byte), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cls_valid(cls_valid),
        .cls_queue(cls_queue)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] bank, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {bank, 5'(idx)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < 4; k++) wr(2'd0, k, 32'd0);
        for (int k = 0; k < 4; k++) wr(2'd1, k, 32'd0);
        for (int k = 0; k < 8; k++) wr(2'd2, k, 32'd0);
        for (int k = 0; k < 16; k++) wr(2'd3, k, 32'd0);
    endtask

    function automatic logic [31:0] t1w(bit ue, bit de, logic [15:0] port,
                                        logic [7:0] ds, logic [3:0] q);
        return (32'(ue) << 29) | (32'(de) << 28) | (32'(port) << 12) |
               (32'(ds) << 4) | 32'(q);
    endfunction

    function automatic logic [31:0] t2w(bit ee, int eix, bit ae, int aix,
                                        bit be, int bix, bit ce, int cix,
                                        logic [3:0] q);
        return (32'(ee) << 12) | (32'(eix & 7) << 9) |
               (32'(ae) << 18) | (32'(aix & 31) << 13) |
               (32'(be) << 24) | (32'(bix & 31) << 19) |
               (32'(ce) << 30) | (32'(cix & 31) << 25) | 32'(q);
    endfunction

    task automatic set_cmp(input int k, input logic [15:0] val, input logic [15:0] msk,
                           input int base, input int off);
        wr(2'd3, 2*k, {val, msk});
        wr(2'd3, 2*k+1, (32'(base & 3) << 7) | 32'(off & 127));
    endtask

    // drive a frame and check strobe timing and queue value
    task automatic send(input int len, input int exp_q, input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (i == 0); rx_last = (i == len - 1);
            rx_byte = fr[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
        check(cls_valid == 1'b0, "R2 early", int'(cls_valid), 0);
        @(negedge clk);
        check(cls_valid == 1'b1, "R2 strobe", int'(cls_valid), 1);
        check(int'(cls_queue) == exp_q, req, int'(cls_queue), exp_q);
        @(negedge clk);
        check(cls_valid == 1'b0, "R2 pulse", int'(cls_valid), 0);
    endtask

    task automatic t_reset();
        check(cls_valid == 1'b0, "R12 reset strobe", int'(cls_valid), 0);
        send(60, 0, "R12 R6 empty config gives queue 0");
    endtask

    task automatic t_tier1();
        wr(2'd0, 1, t1w(1, 0, {fr[36], fr[37]}, 8'h00, 4'd5));
        send(60, 5, "R3 UDP port hit");
        wr(2'd0, 0, t1w(0, 1, 16'h0, fr[15], 4'd3));
        send(60, 3, "R4 R6 DS/TC hit at lower index");
        wr(2'd0, 0, t1w(1, 1, ~{fr[36], fr[37]}, fr[15], 4'd3));
        send(60, 5, "R5 enabled mismatch vetoes screener");
        wr(2'd0, 1, 32'd0);
        wr(2'd0, 2, t1w(0, 0, {fr[36], fr[37]}, fr[15], 4'd9));
        send(60, 0, "R5 no enabled test never hits");
    endtask

    task automatic t_etype();
        clear_cfg();
        wr(2'd2, 3, {16'h0, fr[12], fr[13]});
        wr(2'd1, 2, t2w(1, 3, 0, 0, 0, 0, 0, 0, 4'd7));
        send(60, 7, "R7 EtherType hit");
        wr(2'd0, 3, t1w(0, 1, 16'h0, fr[15], 4'd2));
        send(60, 2, "R6 tier one before tier two");
    endtask

    task automatic t_compare();
        clear_cfg();
        set_cmp(4, {fr[24], 8'hAA}, 16'hFF00, 1, 10);
        wr(2'd1, 0, t2w(0, 0, 1, 4, 0, 0, 0, 0, 4'd9));
        send(60, 9, "R8 R9 compare A masked hit base 14");
        set_cmp(4, {fr[24], 8'hAA}, 16'hFFFF, 1, 10);
        send(60, 0, "R8 full mask mismatch");
        wr(2'd1, 0, 32'd0);
        set_cmp(5, {fr[45], fr[46]}, 16'hFFFF, 3, 3);
        wr(2'd1, 1, t2w(0, 0, 0, 0, 0, 0, 1, 5, 4'd11));
        send(60, 11, "R9 compare C base 42");
        send(46, 0, "R10 low byte past frame end");
        send(47, 11, "R10 frame just long enough");
        set_cmp(6, {fr[34], fr[35]}, 16'hFFFF, 2, 0);
        wr(2'd1, 3, t2w(0, 0, 0, 0, 1, 6, 0, 0, 4'd12));
        send(60, 11, "R6 tier two index order");
        wr(2'd1, 1, 32'd0);
        send(60, 12, "R9 compare B base 34");
        wr(2'd1, 3, t2w(0, 0, 0, 0, 1, 20, 0, 0, 4'd12));
        send(60, 0, "R10 compare index out of range");
    endtask

    task automatic t_writes_and_framing();
        clear_cfg();
        wr(2'd0, 4, t1w(0, 1, 16'h0, fr[15], 4'd6));
        send(60, 0, "R11 out-of-range write ignored");
        wr(2'd0, 0, t1w(1, 0, {fr[36], fr[37]}, 8'h00, 4'd4));
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = 1'b0; rx_last = (i == 39); rx_byte = 8'h11;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(cls_valid == 1'b0, "R1 stray beats ignored", int'(cls_valid), 0);
            @(negedge clk);
        end
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (i == 0); rx_last = 1'b0; rx_byte = 8'h00;
        end
        send(60, 4, "R1 new first byte restarts positions");
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 200; i++) fr[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tier1();
        t_etype();
        t_compare();
        t_writes_and_framing();
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        finish_run();
    end
endmodule